// File: doc/BRIEF.md
# Multi-Step Fibonacci LFSR Word Generator

This block is a Fibonacci linear feedback shift register that moves its sequence forward by WS steps on every enabled clock. The WS bits produced in that clock come out together as one parallel word. A typical use is to feed a parallel-to-serial output stage that must send a pseudorandom test pattern faster than one bit per fabric clock. Parameters set the register length LN, the feedback tap mask TAPS, the nonzero starting fill FILL and the word width WS.

The state is LN+WS-1 bits wide. Its lowest WS bits are the output word. Every new bit is the parity of the upper LN-bit window ANDed with a constant look-ahead tap vector. Tap vector 0 is TAPS. Each later vector is the previous one shifted left by one place, XORed with TAPS when the bit that was shifted out was set, and cut back to LN bits. The block derives all of these vectors, and the extended reset value, during elaboration.

Top module: `lfsr_mstep`

## Requirements
- R1: The stream is numbered from the most recent reset. After N enabled clocks, o_word[i] is stream bit N*WS+i. Bit 0 of the word is the earliest bit in time.
- R2: Stream bits s[0..LN-1] are FILL[0..LN-1]. Every later bit follows the recurrence s[j+LN] = XOR over i of (TAPS[i] AND s[j+i]). The recurrence also holds across the boundary between two consecutive words.
- R3: In the clock after i_rst is high, the low LN state bits equal FILL, whatever i_step is. With the defaults LN=5, TAPS=5'b00101, FILL=5'b00001 and WS=8, the word is then 8'h21.
- R4: While i_rst is low and i_step is low, o_word and the whole state keep their values.
- R5: With a nonzero FILL, the state is never all zeros and no LN consecutive output bits are all zero. For the primitive default mask, the output stream repeats with period 2^LN-1 = 31.
- R6: A reset that arrives in the middle of a run restarts the stream at s[0]. The following words match R1 counted from the new reset.
- R7: The WS-1 state bits above the fill, loaded at reset, already obey the recurrence of R2. The first word after reset is therefore part of the same sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| i_clk | input | 1 | Clock |
| i_rst | input | 1 | Synchronous active-high reset; loads the extended fill |
| i_step | input | 1 | Advance enable; when high the state moves WS steps |
| o_word | output | WS | Registered word of WS consecutive sequence bits, earliest in bit 0 |

## Verification
The bench checks the word after reset against a literal value, because an extended reset value that was computed wrong would give bad upper bits only in the very first word. It stops and restarts the enable at irregular points, where a design that ignored the enable or lost its place would drift off the reference stream. It checks the recurrence on the collected output bits across word boundaries and over several full periods, which catches a tap vector with the wrong feedback fold, since that error appears only deep inside a word. A reset in mid-run shows whether the design truly returns to bit zero of the sequence.

// File: rtl/lfsr_mstep_pkg.sv
package lfsr_mstep_pkg;

  // Widest register length the tap helpers support
  localparam int unsigned MAX_LEN = 64;

  typedef logic [MAX_LEN-1:0] lfsr_vec_t;

  // Mask that keeps the low len bits
  function automatic lfsr_vec_t low_mask(int unsigned len);
    lfsr_vec_t m;
    for (int unsigned i = 0; i < MAX_LEN; i++) begin
      m[i] = (i < len);
    end
    return m;
  endfunction

  // Next look-ahead tap vector: shift up, fold the feedback back in
  function automatic lfsr_vec_t advance_tapv(lfsr_vec_t prev, lfsr_vec_t taps,
                                             int unsigned len);
    lfsr_vec_t nv;
    nv = prev << 1;
    if (prev[len-1]) begin
      nv = nv ^ taps;
    end
    return nv & low_mask(len);
  endfunction

endpackage

// File: rtl/lfsr_lookahead.sv
module lfsr_lookahead
  import lfsr_mstep_pkg::*;
#(
  parameter int unsigned          LN   = 5,
  parameter int unsigned          WS   = 8,
  parameter logic [LN-1:0]        TAPS = 5'b00101,
  localparam int unsigned         SW   = LN + WS - 1
) (
  input  logic [LN-1:0] win,
  output logic [SW-1:0] nxt
);

  // Tap vector k, rebuilt from TAPS during elaboration
  function automatic lfsr_vec_t tapv_at(int unsigned k);
    lfsr_vec_t v;
    v = lfsr_vec_t'(TAPS);
    for (int unsigned i = 0; i < k; i++) begin
      v = advance_tapv(v, lfsr_vec_t'(TAPS), LN);
    end
    return v;
  endfunction

  // The bits that are already known simply move down
  assign nxt[LN-2:0] = win[LN-1:1];

  // Each new bit is the parity of the window under its own tap vector
  for (genvar k = 0; k < WS; k++) begin : g_new_bit
    localparam lfsr_vec_t TV = tapv_at(k);
    assign nxt[LN-1+k] = ^(win & TV[LN-1:0]);
  end

endmodule

// File: rtl/lfsr_state_reg.sv
module lfsr_state_reg #(
  parameter int unsigned    SW      = 12,
  parameter logic [SW-1:0]  RST_VAL = '1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [SW-1:0] d,
  output logic [SW-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= RST_VAL;
    end else if (en) begin
      q <= d;
    end
  end

endmodule

// File: rtl/lfsr_mstep.sv
module lfsr_mstep #(
  parameter int unsigned   LN   = 5,
  parameter logic [LN-1:0] TAPS = 5'b00101,
  parameter logic [LN-1:0] FILL = 5'b00001,
  parameter int unsigned   WS   = 8
) (
  input  logic          i_clk,
  input  logic          i_rst,
  input  logic          i_step,
  output logic [WS-1:0] o_word
);

  localparam int unsigned SW = LN + WS - 1;

  // Fill extended by WS-1 bits that obey the recurrence
  function automatic logic [SW-1:0] extend_fill();
    logic [SW-1:0] r;
    r          = '0;
    r[LN-1:0]  = FILL;
    for (int j = 0; j < int'(WS) - 1; j++) begin
      r[LN+j] = ^(r[j +: LN] & TAPS);
    end
    return r;
  endfunction

  localparam logic [SW-1:0] RST_VAL = extend_fill();

  if (LN < 2 || LN > 64 || WS < 1) begin : g_bad_size
    $error("lfsr_mstep: LN must be 2..64 and WS at least 1");
  end
  if (FILL == '0 || TAPS == '0) begin : g_bad_fill
    $error("lfsr_mstep: FILL and TAPS must be nonzero");
  end

  logic [SW-1:0] state_q;
  logic [SW-1:0] state_d;

  lfsr_lookahead #(
    .LN   (LN),
    .WS   (WS),
    .TAPS (TAPS)
  ) u_ahead (
    .win (state_q[SW-1:WS-1]),
    .nxt (state_d)
  );

  lfsr_state_reg #(
    .SW      (SW),
    .RST_VAL (RST_VAL)
  ) u_state (
    .clk (i_clk),
    .rst (i_rst),
    .en  (i_step),
    .d   (state_d),
    .q   (state_q)
  );

  assign o_word = state_q[WS-1:0];

endmodule

// File: rtl/lfsr_mstep_chk.sv
module lfsr_mstep_chk #(
  parameter int unsigned   LN   = 5,
  parameter logic [LN-1:0] TAPS = 5'b00101,
  parameter logic [LN-1:0] FILL = 5'b00001,
  parameter int unsigned   WS   = 8,
  localparam int unsigned  SW   = LN + WS - 1
) (
  input logic          clk,
  input logic          rst,
  input logic          step,
  input logic [SW-1:0] state
);

  // R3: fill present right after any reset
  a_r3_fill_after_reset: assert property (@(posedge clk)
    $past(rst) |-> state[LN-1:0] == FILL);

  // R4: disabled step keeps the state
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(state));

  // R5: never the lock-up state
  a_r5_nonzero: assert property (@(posedge clk) disable iff (rst)
    state != '0);

  // R2, R7: every bit inside the state obeys the recurrence
  for (genvar j = 0; j + LN < SW; j++) begin : g_inner
    a_r2_inner_recur: assert property (@(posedge clk) disable iff (rst)
      state[j+LN] == ^(state[j +: LN] & TAPS));
  end

  // R2: link between the last old bit and the new low bits
  a_r2_boundary: assert property (@(posedge clk) disable iff (rst)
    step |=> state[LN-1] == ^({state[LN-2:0], $past(state[WS-1])} & TAPS));

endmodule

bind lfsr_mstep lfsr_mstep_chk #(
  .LN   (LN),
  .TAPS (TAPS),
  .FILL (FILL),
  .WS   (WS)
) u_chk (
  .clk   (i_clk),
  .rst   (i_rst),
  .step  (i_step),
  .state (state_q)
);

// File: tb/lfsr_mstep_tb_top.sv
module lfsr_mstep_tb_top;

  localparam int          LN     = 5;
  localparam int          WS     = 8;
  localparam logic [4:0]  TAPS   = 5'b00101;
  localparam logic [4:0]  FILL   = 5'b00001;
  localparam int          PERIOD = 31;

  logic          clk  = 1'b0;
  logic          rst  = 1'b1;
  logic          step = 1'b0;
  logic [WS-1:0] word;

  always #5 clk = ~clk;

  lfsr_mstep #(
    .LN   (LN),
    .TAPS (TAPS),
    .FILL (FILL),
    .WS   (WS)
  ) dut_i (
    .i_clk  (clk),
    .i_rst  (rst),
    .i_step (step),
    .o_word (word)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  bit ref_q[$];     // reference stream, bit-serial
  bit hist[$];      // bits actually seen on o_word since reset
  int pos = 0;
  logic [WS-1:0] prev_word;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Grow the reference one bit at a time
  task automatic ref_extend(int upto);
    while (ref_q.size() <= upto) begin
      int j = ref_q.size() - LN;
      bit nb = 1'b0;
      for (int i = 0; i < LN; i++) begin
        if (TAPS[i]) nb ^= ref_q[j+i];
      end
      ref_q.push_back(nb);
    end
  endtask

  task automatic ref_init();
    ref_q.delete();
    for (int i = 0; i < LN; i++) ref_q.push_back(FILL[i]);
  endtask

  // Checks on the bits collected from the port
  task automatic hist_checks();
    bit rec_ok = 1'b1;
    bit nz_ok  = 1'b1;
    bit per_ok = 1'b1;
    bit per_seen = 1'b0;
    for (int n = hist.size() - WS; n < hist.size(); n++) begin
      if (n >= LN) begin
        bit e = 1'b0;
        for (int i = 0; i < LN; i++) if (TAPS[i]) e ^= hist[n-LN+i];
        if (hist[n] != e) rec_ok = 1'b0;
      end
      if (n >= LN - 1) begin
        bit any = 1'b0;
        for (int i = 0; i < LN; i++) any |= hist[n-i];
        if (!any) nz_ok = 1'b0;
      end
      if (n >= PERIOD) begin
        per_seen = 1'b1;
        if (hist[n] != hist[n-PERIOD]) per_ok = 1'b0;
      end
    end
    check(rec_ok, "R2", "recurrence on port bits", rec_ok, 1);
    check(nz_ok,  "R5", "no all-zero window", nz_ok, 1);
    if (per_seen) check(per_ok, "R5", "period 31", per_ok, 1);
  endtask

  task automatic cycle(bit s, bit r);
    logic [WS-1:0] exp;
    @(negedge clk);
    step = s;
    rst  = r;
    prev_word = word;
    @(posedge clk);
    #1;
    if (r) begin
      pos = 0;
      hist.delete();
    end else if (s) begin
      pos += WS;
    end
    ref_extend(pos + WS);
    for (int i = 0; i < WS; i++) exp[i] = ref_q[pos+i];
    if (r) begin
      check(word[LN-1:0] == FILL, "R3", "fill after reset", word[LN-1:0], FILL);
      check(word == exp, "R7", "extended reset word", word, exp);
    end else if (!s) begin
      check(word == prev_word, "R4", "hold with step low", word, prev_word);
    end else begin
      check(word == exp, "R1", "word vs reference", word, exp);
    end
    if (r || s) begin
      for (int i = 0; i < WS; i++) hist.push_back(word[i]);
      hist_checks();
    end
  endtask

  initial begin
    ref_init();
    // Reset while step is high: reset wins
    cycle(1'b1, 1'b1);
    cycle(1'b0, 1'b1);
    check(word == 8'h21, "R3", "literal first word", word, 8'h21);
    for (int i = 0; i < 60; i++) cycle(1'b1, 1'b0);
    // Irregular enable pattern
    for (int i = 0; i < 40; i++) cycle((i % 3) != 0 && (i % 7) != 2, 1'b0);
    for (int i = 0; i < 5; i++) cycle(1'b0, 1'b0);
    // Reset in mid-run restarts at s[0]
    cycle(1'b1, 1'b1);
    check(word == 8'h21, "R6", "restart word", word, 8'h21);
    for (int i = 0; i < 30; i++) cycle(1'b1, 1'b0);
    cycle(1'b0, 1'b1);
    for (int i = 0; i < 120; i++) cycle((i % 5) != 4, 1'b0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R1 watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule